// File: doc/BRIEF.md
# Paired Address/Data Register Memory Port

This block gives a small processor three apparent memory ports backed by one single-ported word memory. Each port is a pair of 16-bit registers: an address register and a data register. The processor writes results into any one of the six registers over a 16-bit result bus, chosen by a 3-bit destination code and a write strobe. Loading an address register fetches the addressed word into its partner data register on the same clock edge. Loading a data register stores the value to memory at the address its partner already holds.

All six registers are edge-triggered flip-flops. A data value can therefore be fed back as the next address, as in a linked-list walk, and still stay stable for the whole cycle. One shared address selector picks the memory address from four sources: the result bus, or the address register of pair 1, 2 or 3. The internal data bus has two drivers, the memory output and the result-bus path, and their enables are always complementary. A takeover input takes the address away from the block so that an outside agent can look at memory. While it is held, destination writes are blocked.

The memory depth is a parameter (`MEM_AW` address bits). It defaults to 4096 words so that the default build stays small. Setting `MEM_AW` to 16 gives the full 65536 words. Register bits above `MEM_AW` do not take part in memory addressing.

Top module: `adrm_port`

## Requirements
- R1: While reset is held and after it is released, all six registers read zero and `rd_valid` is 3'b000.
- R2: With `dst_we`=1, `takeover`=0 and `dst_sel` = k (k in 0..2), the next rising edge loads address register k+1 with `res_bus`. On the same edge, data register k+1 is loaded with the memory word at `res_bus`.
- R3: With `dst_we`=1, `takeover`=0 and `dst_sel` = 3+k (k in 0..2), the next edge loads data register k+1 with `res_bus`. On the same edge, the value is stored to memory at the address held in address register k+1, so a later load of that address returns it.
- R4: `mem_addr` shows the address in use: `res_bus` during an address-register write, the paired address register during a data-register write, and address register 1 when no write is active.
- R5: `dst_sel` codes 6 and 7, or `dst_we`=0, change no register and no memory word.
- R6: `data_bus` carries `res_bus` during a data-register write and the memory word at `mem_addr` at all other times. The memory output and the result path never drive it together.
- R7: Writing address register 1 with the current value of data register 1 follows one link per cycle. The fetched word is the one at the old data value.
- R8: `rd_valid` bit k is 1 for exactly the one cycle after address register k+1 is written, and no two bits are 1 at once.
- R9: While `takeover`=1, `mem_addr` equals `ext_addr` and `data_bus` shows the memory word there. Any destination write in that cycle is ignored.
- R10: Only the low `MEM_AW` bits of an address select a memory word. With the default of 12, addresses 16'h1005 and 16'h0005 name the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_bus | input | 16 | Result bus value to write |
| dst_sel | input | 3 | Destination: 0-2 address regs 1-3, 3-5 data regs 1-3, 6-7 none |
| dst_we | input | 1 | Destination write strobe |
| takeover | input | 1 | External agent owns the memory address |
| ext_addr | input | 16 | Address used while `takeover` is high |
| a_regs | output | 48 | Address registers, pair k at bits [16k+15:16k] |
| d_regs | output | 48 | Data registers, pair k at bits [16k+15:16k] |
| rd_valid | output | 3 | Per-pair pulse one cycle after an address write |
| mem_addr | output | 16 | Selected memory address |
| data_bus | output | 16 | Internal memory data bus value |

## Verification
A takeover and a destination write can arrive in the same cycle. The bench provokes this by raising `takeover` together with `dst_we` for both an address-register code and a data-register code, each with a result value that differs from everything already stored. It judges the outcome in three ways: `mem_addr` and `data_bus` must follow `ext_addr` during that cycle, both register banks must be unchanged after the edge, and the word at the paired address must read back with its old value once takeover drops. Read-after-write across a boundary is also covered: a store is followed at once by a load of the same address, and a load of an aliased address (R10).

// File: rtl/adrm_pkg.sv
package adrm_pkg;
   // Source that owns the memory address in the current cycle
   typedef enum logic [1:0] {
      ROUTE_IDLE   = 2'd0,
      ROUTE_ALOAD  = 2'd1,
      ROUTE_DSTORE = 2'd2,
      ROUTE_EXT    = 2'd3
   } route_e;
endpackage

// File: rtl/adrm_decode.sv
module adrm_decode
   import adrm_pkg::*;
#(
   parameter int NPAIR = 3,
   parameter int SEL_W = 3,
   localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
   input  logic [SEL_W-1:0] dst_sel,
   input  logic             dst_we,
   input  logic             takeover,
   output logic [NPAIR-1:0] a_we,
   output logic [NPAIR-1:0] d_we,
   output logic             mem_we,
   output route_e           route,
   output logic [IDX_W-1:0] pair_idx
);
   logic strobe;
   assign strobe = dst_we & ~takeover;

   for (genvar i = 0; i < NPAIR; i++) begin : g_dec
      assign a_we[i] = strobe && (dst_sel == SEL_W'(i));
      assign d_we[i] = strobe && (dst_sel == SEL_W'(NPAIR + i));
   end

   assign mem_we = |d_we;

   always_comb begin
      pair_idx = '0;
      for (int i = 0; i < NPAIR; i++) begin
         if (a_we[i] || d_we[i]) pair_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (takeover)      route = ROUTE_EXT;
      else if (|a_we)    route = ROUTE_ALOAD;
      else if (|d_we)    route = ROUTE_DSTORE;
      else               route = ROUTE_IDLE;
   end
endmodule

// File: rtl/adrm_addr_mux.sv
module adrm_addr_mux
   import adrm_pkg::*;
#(
   parameter int NPAIR = 3,
   parameter int DW    = 16,
   parameter int IDLE_PAIR = 0,
   localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
   input  route_e                      route,
   input  logic [IDX_W-1:0]            pair_idx,
   input  logic [DW-1:0]               res_bus,
   input  logic [NPAIR-1:0][DW-1:0]    a_q,
   input  logic [DW-1:0]               ext_addr,
   input  logic [DW-1:0]               mem_q,
   output logic [DW-1:0]               addr,
   output logic [DW-1:0]               data_bus,
   output logic                        mem_oe,
   output logic                        res_oe
);
   initial assert (IDLE_PAIR >= 0 && IDLE_PAIR < NPAIR)
      else $error("IDLE_PAIR out of range");

   always_comb begin
      unique case (route)
         ROUTE_ALOAD:  addr = res_bus;
         ROUTE_DSTORE: addr = a_q[pair_idx];
         ROUTE_EXT:    addr = ext_addr;
         default:      addr = a_q[IDLE_PAIR];
      endcase
   end

   // Exactly one driver owns the internal data bus
   assign res_oe   = (route == ROUTE_DSTORE);
   assign mem_oe   = ~res_oe;
   assign data_bus = res_oe ? res_bus : mem_q;
endmodule

// File: rtl/adrm_mem.sv
module adrm_mem #(
   parameter int DW     = 16,
   parameter int MEM_AW = 12,
   localparam int DEPTH = 1 << MEM_AW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [DW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   initial assert (MEM_AW >= 1 && MEM_AW <= DW)
      else $error("MEM_AW must lie in 1..DW");

   logic [DW-1:0]     store [DEPTH];
   logic [MEM_AW-1:0] idx;

   assign idx = addr[MEM_AW-1:0];
   assign q   = store[idx];

   always_ff @(posedge clk) begin
      if (we) store[idx] <= wdata;
   end
endmodule

// File: rtl/adrm_regfile.sv
module adrm_regfile #(
   parameter int NPAIR = 3,
   parameter int DW    = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NPAIR-1:0]         a_we,
   input  logic [NPAIR-1:0]         d_we,
   input  logic [DW-1:0]            res_bus,
   input  logic [DW-1:0]            mem_q,
   output logic [NPAIR-1:0][DW-1:0] a_q,
   output logic [NPAIR-1:0][DW-1:0] d_q,
   output logic [NPAIR-1:0]         rd_valid
);
   for (genvar i = 0; i < NPAIR; i++) begin : g_pair
      // Edge-triggered only: a D value used as the next address stays put
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q[i]      <= '0;
            d_q[i]      <= '0;
            rd_valid[i] <= 1'b0;
         end else begin
            rd_valid[i] <= a_we[i];
            if (a_we[i]) begin
               a_q[i] <= res_bus;
               d_q[i] <= mem_q;
            end else if (d_we[i]) begin
               d_q[i] <= res_bus;
            end
         end
      end

      // R2 address register takes the result bus
      a_r2_aload: assert property (@(posedge clk) disable iff (!rst_n)
         a_we[i] |=> a_q[i] == $past(res_bus));
      // R3 data register takes the result bus
      a_r3_dload: assert property (@(posedge clk) disable iff (!rst_n)
         d_we[i] |=> d_q[i] == $past(res_bus));
      // R8 pulse follows the address write
      a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         a_we[i] |=> rd_valid[i]);
      // R5 idle pair holds its state
      a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !(a_we[i] || d_we[i]) |=> $stable(a_q[i]) && $stable(d_q[i]));
   end

   // R8 never two pulses at once
   a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_valid));
endmodule

// File: rtl/adrm_port.sv
module adrm_port
   import adrm_pkg::*;
#(
   parameter int DW     = 16,
   parameter int NPAIR  = 3,
   parameter int SEL_W  = 3,
   parameter int MEM_AW = 12,
   localparam int IDX_W = (NPAIR > 1) ? $clog2(NPAIR) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DW-1:0]        res_bus,
   input  logic [SEL_W-1:0]     dst_sel,
   input  logic                 dst_we,
   input  logic                 takeover,
   input  logic [DW-1:0]        ext_addr,
   output logic [NPAIR*DW-1:0]  a_regs,
   output logic [NPAIR*DW-1:0]  d_regs,
   output logic [NPAIR-1:0]     rd_valid,
   output logic [DW-1:0]        mem_addr,
   output logic [DW-1:0]        data_bus
);
   initial assert (NPAIR >= 1 && 2 * NPAIR <= (1 << SEL_W))
      else $error("destination code too narrow for NPAIR pairs");

   logic [NPAIR-1:0]         a_we, d_we;
   logic                     mem_we, mem_oe, res_oe;
   route_e                   route;
   logic [IDX_W-1:0]         pair_idx;
   logic [NPAIR-1:0][DW-1:0] a_q, d_q;
   logic [DW-1:0]            mem_q;

   adrm_decode #(.NPAIR(NPAIR), .SEL_W(SEL_W)) u_dec (
      .dst_sel(dst_sel), .dst_we(dst_we), .takeover(takeover),
      .a_we(a_we), .d_we(d_we), .mem_we(mem_we),
      .route(route), .pair_idx(pair_idx));

   adrm_addr_mux #(.NPAIR(NPAIR), .DW(DW), .IDLE_PAIR(0)) u_mux (
      .route(route), .pair_idx(pair_idx), .res_bus(res_bus), .a_q(a_q),
      .ext_addr(ext_addr), .mem_q(mem_q), .addr(mem_addr),
      .data_bus(data_bus), .mem_oe(mem_oe), .res_oe(res_oe));

   adrm_mem #(.DW(DW), .MEM_AW(MEM_AW)) u_mem (
      .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(res_bus), .q(mem_q));

   adrm_regfile #(.NPAIR(NPAIR), .DW(DW)) u_regs (
      .clk(clk), .rst_n(rst_n), .a_we(a_we), .d_we(d_we),
      .res_bus(res_bus), .mem_q(mem_q),
      .a_q(a_q), .d_q(d_q), .rd_valid(rd_valid));

   assign a_regs = a_q;
   assign d_regs = d_q;

   // R6 memory output never drives while a store is in flight
   a_r6_bus_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_oe && mem_we) && (mem_oe != res_oe));
   // R9 takeover freezes every register
   a_r9_takeover_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      takeover |=> $stable(a_q) && $stable(d_q));
   // R9 takeover hands the address to the outside agent
   a_r9_takeover_addr: assert property (@(posedge clk) disable iff (!rst_n)
      takeover |-> mem_addr == ext_addr);
endmodule

// File: tb/adrm_port_test.sv
module adrm_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] res_bus = '0;
   logic [2:0]  dst_sel = 3'd7;
   logic        dst_we = 1'b0;
   logic        takeover = 1'b0;
   logic [15:0] ext_addr = '0;
   logic [47:0] a_regs, d_regs;
   logic [2:0]  rd_valid;
   logic [15:0] mem_addr, data_bus;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   adrm_port uut (
      .clk(clk), .rst_n(rst_n), .res_bus(res_bus), .dst_sel(dst_sel),
      .dst_we(dst_we), .takeover(takeover), .ext_addr(ext_addr),
      .a_regs(a_regs), .d_regs(d_regs), .rd_valid(rd_valid),
      .mem_addr(mem_addr), .data_bus(data_bus));

   function automatic logic [15:0] ga(input int k);
      return a_regs[k*16 +: 16];
   endfunction
   function automatic logic [15:0] gd(input int k);
      return d_regs[k*16 +: 16];
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One write cycle, outputs sampled 1 ns after the edge
   task automatic op(input logic [2:0] s, input logic [15:0] r);
      @(negedge clk); dst_sel = s; dst_we = 1'b1; res_bus = r;
      @(posedge clk); #1; dst_we = 1'b0; dst_sel = 3'd7;
   endtask

   task automatic idle_cycle();
      @(posedge clk); #1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
         chk("R1 addr reg in reset", ga(k), 16'h0);
         chk("R1 data reg in reset", gd(k), 16'h0);
      end
      chk("R1 rd_valid in reset", {13'h0, rd_valid}, 16'h0);
      rst_n = 1'b1;
      idle_cycle();
      chk("R1 addr reg after reset", ga(2), 16'h0);
   endtask

   task automatic t_store_load();
      op(3'd1, 16'h0040);            // A2 = 0x40
      chk("R2 A2 loaded", ga(1), 16'h0040);
      op(3'd4, 16'hBEEF);            // D2 stores to mem[0x40]
      chk("R3 D2 loaded", gd(1), 16'hBEEF);
      op(3'd2, 16'h0040);            // A3 = 0x40 fetches stored word
      chk("R2 A3 loaded", ga(2), 16'h0040);
      chk("R3 stored word fetched into D3", gd(2), 16'hBEEF);
      op(3'd0, 16'h0041);
      op(3'd3, 16'h1234);            // mem[0x41]
      op(3'd0, 16'h0040);
      chk("R2 D1 fetch", gd(0), 16'hBEEF);
   endtask

   task automatic t_valid();
      op(3'd2, 16'h0041);
      chk("R8 pulse after A3 write", {13'h0, rd_valid}, 16'h0004);
      chk("R2 D3 fetch of 0x41", gd(2), 16'h1234);
      idle_cycle();
      chk("R8 pulse lasts one cycle", {13'h0, rd_valid}, 16'h0000);
      op(3'd5, 16'h0000 | 16'h1234);
      chk("R8 no pulse after D write", {13'h0, rd_valid}, 16'h0000);
   endtask

   task automatic t_mux_bus();
      // A1 = 0x40 holds BEEF
      @(negedge clk); #1;
      chk("R4 idle address is A1", mem_addr, ga(0));
      chk("R6 idle bus is memory word", data_bus, 16'hBEEF);
      dst_sel = 3'd1; dst_we = 1'b1; res_bus = 16'h0041; #1;
      chk("R4 address is result bus on A write", mem_addr, 16'h0041);
      chk("R6 bus is memory word on A write", data_bus, 16'h1234);
      dst_sel = 3'd5; res_bus = 16'h7777; #1;
      chk("R4 address is A3 on D3 write", mem_addr, ga(2));
      chk("R6 bus is result on D write", data_bus, 16'h7777);
      dst_we = 1'b0; dst_sel = 3'd7;
   endtask

   task automatic t_noop();
      logic [47:0] sa, sd;
      sa = a_regs; sd = d_regs;
      op(3'd6, 16'hDEAD);
      op(3'd7, 16'hDEAD);
      @(negedge clk); dst_sel = 3'd3; dst_we = 1'b0; res_bus = 16'hDEAD;
      @(posedge clk); #1; dst_sel = 3'd7;
      chk("R5 addr regs unchanged lo", sa[15:0], a_regs[15:0]);
      chk("R5 addr regs unchanged hi", sa[47:32], a_regs[47:32]);
      chk("R5 data regs unchanged", sd[31:0] == d_regs[31:0] ? 16'h1 : 16'h0, 16'h1);
      @(negedge clk);
      chk("R5 memory at A1 unchanged", data_bus, 16'hBEEF);
   endtask

   task automatic t_linked_list();
      op(3'd1, 16'h0010); op(3'd4, 16'h0020);
      op(3'd1, 16'h0020); op(3'd4, 16'h0030);
      op(3'd1, 16'h0030); op(3'd4, 16'hABCD);
      op(3'd0, 16'h0010);
      chk("R7 first link", gd(0), 16'h0020);
      op(3'd0, gd(0));
      chk("R7 second link", gd(0), 16'h0030);
      chk("R7 address follows", ga(0), 16'h0020);
      op(3'd0, gd(0));
      chk("R7 list tail", gd(0), 16'hABCD);
   endtask

   task automatic t_takeover();
      logic [47:0] sa, sd;
      op(3'd0, 16'h0040);            // A1 -> BEEF word
      sa = a_regs; sd = d_regs;
      @(negedge clk);
      takeover = 1'b1; ext_addr = 16'h0041;
      dst_sel = 3'd3; dst_we = 1'b1; res_bus = 16'h5555; #1;
      chk("R9 address follows ext_addr", mem_addr, 16'h0041);
      chk("R9 bus shows word at ext_addr", data_bus, 16'h1234);
      @(posedge clk); #1;
      dst_sel = 3'd1; res_bus = 16'h6666;
      @(posedge clk); #1;
      takeover = 1'b0; dst_we = 1'b0; dst_sel = 3'd7;
      chk("R9 addr regs frozen", a_regs == sa ? 16'h1 : 16'h0, 16'h1);
      chk("R9 data regs frozen", d_regs == sd ? 16'h1 : 16'h0, 16'h1);
      @(negedge clk);
      chk("R9 memory at A1 not written", data_bus, 16'hBEEF);
   endtask

   task automatic t_alias();
      op(3'd0, 16'h0005);
      op(3'd3, 16'h5A5A);
      op(3'd1, 16'h1005);
      chk("R10 high bits ignored", gd(1), 16'h5A5A);
   endtask

   initial begin
      #(8 * 100000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_store_load();
      t_valid();
      t_mux_bus();
      t_noop();
      t_linked_list();
      t_takeover();
      t_alias();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule